// File: doc/BRIEF.md
# Adder-Only Latching-Mux Datapath

This block is a 16-bit processor datapath in which a binary adder is the only arithmetic element. Each adder input is fed by a gated mux with OR semantics. Every source has its own enable, and any subset of the enables may be on in the same cycle. When several sources are enabled, their data are ORed. When none is enabled, the mux gives zero. The A side can take register data, inverted register data and inverted bus data. The B side can take register data and bus data. Each mux output can be captured into a holding latch, and that latch can be selected again as one more source. This lets an operand stay in place while the register or bus inputs change.

The adder result passes through an output stage before it leaves the block. That stage can pass the sum unchanged, shift it left by one bit, shift it right by one bit as an arithmetic shift, rotate it by one bit through the stored carry, or swap its two bytes. The block also computes negative, zero, overflow and carry flags from the output stage. It stores them when the controller asks.

Other operations are built from these pieces. OR comes from enabling several sources at once. AND takes two passes using De Morgan's law. Subtraction uses inverted bus data plus a carry-in. Constants come from the gating of the A side, where bit 0 has its own enables. Selecting both register and inverted register gives all ones. Changing only bit 0 of that gives -2 or +1. Register storage and sequencing are outside the block.

Top module: `adder_mux_datapath`

## Requirements
- R1: After reset, both holding latches are zero and all four flags (flag_n, flag_z, flag_v, flag_c) are zero.
- R2: A mux with no enabled source contributes zero, so with all enables off the pass-through result equals carry_in.
- R3: Enabling several sources on one mux yields their bitwise OR. The bits of a_gate_hi and a_gate_lo are: bit 0 register, bit 1 inverted register, bit 2 inverted bus, bit 3 A latch. The bits of b_gate are: bit 0 register, bit 1 bus, bit 2 B latch.
- R4: a_gate_hi drives A-mux bits 15..1 and a_gate_lo drives A-mux bit 0 on their own. Register plus inverted register gives 0xFFFF. Enabling both only in a_gate_hi gives 0xFFFE. Enabling both only in a_gate_lo gives 0x0001.
- R5: On a clock edge with a_capture (or b_capture) high, the A (or B) latch stores the current mux output. Otherwise the latch holds its value. Selecting the latch later presents the stored value as a source.
- R6: With out_mode 0 (and also 6 and 7), result is the low 16 bits of A + B + carry_in.
- R7: out_mode 1 shifts the sum left by one bit, filling bit 0 with zero. out_mode 2 shifts the sum right by one bit, keeping bit 15.
- R8: out_mode 3 rotates the sum left through the stored flag_c, which enters bit 0. out_mode 4 rotates the sum right through flag_c, which enters bit 15.
- R9: out_mode 5 exchanges the upper and lower bytes of the sum.
- R10: On a clock edge with flags_load high, the flags are set as follows. N is bit 15 of result. Z is set when result is zero. For pass-through, C is the adder carry-out and V is signed overflow of the addition. For shifts and rotates, C is the bit shifted out and V is N XOR C. For byte swap, C and V are 0. Without flags_load, the flags hold.
- R11: A bitwise AND can be formed in two passes. The first pass ORs the inverted operands. The second pass selects the inverted register with that value as register data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_data | input | 16 | Register-file read data |
| bus_data | input | 16 | Bus read data |
| a_gate_hi | input | 4 | A-mux source enables for bits 15..1 |
| a_gate_lo | input | 4 | A-mux source enables for bit 0 |
| b_gate | input | 3 | B-mux source enables |
| a_capture | input | 1 | Load the A latch from the A mux |
| b_capture | input | 1 | Load the B latch from the B mux |
| carry_in | input | 1 | Adder carry-in |
| out_mode | input | 3 | Output stage operation |
| flags_load | input | 1 | Update the condition flags |
| result | output | 16 | Output-stage result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
A wrong value in a holding latch stays hidden until the latch is selected as a source. It then shows on result in that same cycle. For this reason the bench captures a value, changes the register and bus inputs, and then selects the latch. A wrong stored flag shows on the flag ports one cycle after the load. It shows on result one cycle after that, when a rotate pulls flag_c into the end bit. A reference model that keeps its own latch and flag state is compared with the ports on every clock, so such a fault is caught within one or two cycles.

// File: rtl/adder_mux_datapath.sv
module adder_mux_datapath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] reg_data,
  input  logic [WIDTH-1:0] bus_data,
  input  logic [3:0]       a_gate_hi,
  input  logic [3:0]       a_gate_lo,
  input  logic [2:0]       b_gate,
  input  logic             a_capture,
  input  logic             b_capture,
  input  logic             carry_in,
  input  logic [2:0]       out_mode,
  input  logic             flags_load,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] a_lat, b_lat, a_hi, a_lo, a_mux, b_mux, sum;
  logic             carry_out, add_ovf, nxt_c, nxt_v;

  function automatic logic [WIDTH-1:0] gate(input logic en, input logic [WIDTH-1:0] d);
    return en ? d : '0;
  endfunction

  assign a_hi  = gate(a_gate_hi[0], reg_data) | gate(a_gate_hi[1], ~reg_data)
               | gate(a_gate_hi[2], ~bus_data) | gate(a_gate_hi[3], a_lat);
  assign a_lo  = gate(a_gate_lo[0], reg_data) | gate(a_gate_lo[1], ~reg_data)
               | gate(a_gate_lo[2], ~bus_data) | gate(a_gate_lo[3], a_lat);
  assign a_mux = {a_hi[MSB:1], a_lo[0]};
  assign b_mux = gate(b_gate[0], reg_data) | gate(b_gate[1], bus_data) | gate(b_gate[2], b_lat);

  assign {carry_out, sum} = {1'b0, a_mux} + {1'b0, b_mux} + {{WIDTH{1'b0}}, carry_in};
  assign add_ovf = (a_mux[MSB] == b_mux[MSB]) && (sum[MSB] != a_mux[MSB]);

  always_comb begin
    result = sum;
    nxt_c  = carry_out;
    nxt_v  = add_ovf;
    case (out_mode)
      3'd1: begin result = {sum[MSB-1:0], 1'b0};   nxt_c = sum[MSB]; nxt_v = result[MSB] ^ nxt_c; end
      3'd2: begin result = {sum[MSB], sum[MSB:1]}; nxt_c = sum[0];   nxt_v = result[MSB] ^ nxt_c; end
      3'd3: begin result = {sum[MSB-1:0], flag_c}; nxt_c = sum[MSB]; nxt_v = result[MSB] ^ nxt_c; end
      3'd4: begin result = {flag_c, sum[MSB:1]};   nxt_c = sum[0];   nxt_v = result[MSB] ^ nxt_c; end
      3'd5: begin result = {sum[HALF-1:0], sum[MSB:HALF]}; nxt_c = 1'b0; nxt_v = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_lat <= '0;
      b_lat <= '0;
    end else begin
      if (a_capture) a_lat <= a_mux;
      if (b_capture) b_lat <= b_mux;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {flag_n, flag_z, flag_v, flag_c} <= 4'b0000;
    else if (flags_load) begin
      flag_n <= result[MSB];
      flag_z <= (result == '0);
      flag_v <= nxt_v;
      flag_c <= nxt_c;
    end
endmodule

module adder_mux_datapath_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       a_gate_hi,
  input logic [3:0]       a_gate_lo,
  input logic [2:0]       b_gate,
  input logic             a_capture,
  input logic             b_capture,
  input logic             carry_in,
  input logic [2:0]       out_mode,
  input logic             flags_load,
  input logic [WIDTH-1:0] a_mux,
  input logic [WIDTH-1:0] b_mux,
  input logic [WIDTH-1:0] a_lat,
  input logic [WIDTH-1:0] b_lat,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);
  AST_A_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    a_capture |=> a_lat == $past(a_mux)); // R5
  AST_B_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !b_capture |=> $stable(b_lat)); // R5
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_load |=> $stable({flag_n, flag_z, flag_v, flag_c})); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flags_load |=> flag_z == ($past(result) == '0)); // R10
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flags_load |=> flag_n == $past(result[WIDTH-1])); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_gate_hi == 4'd0 && a_gate_lo == 4'd0 && b_gate == 3'd0 && !carry_in && out_mode == 3'd0)
      |-> result == '0); // R2
endmodule

bind adder_mux_datapath adder_mux_datapath_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .a_gate_hi(a_gate_hi), .a_gate_lo(a_gate_lo),
  .b_gate(b_gate), .a_capture(a_capture), .b_capture(b_capture),
  .carry_in(carry_in), .out_mode(out_mode), .flags_load(flags_load),
  .a_mux(a_mux), .b_mux(b_mux), .a_lat(a_lat), .b_lat(b_lat), .result(result),
  .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

// File: tb/test_adder_mux_datapath.sv
`timescale 1ns/1ps
module test_adder_mux_datapath;
  logic clk = 0, rst_n = 0;
  logic [15:0] reg_data = 0, bus_data = 0;
  logic [3:0] a_gate_hi = 0, a_gate_lo = 0;
  logic [2:0] b_gate = 0, out_mode = 0;
  logic a_capture = 0, b_capture = 0, carry_in = 0, flags_load = 0;
  logic [15:0] result;
  logic flag_n, flag_z, flag_v, flag_c;
  int tests = 0, fails = 0;
  int ma = 0, mb = 0;
  int mn = 0, mz = 0, mv = 0, mc = 0;

  always #2 clk = ~clk;

  adder_mux_datapath i_adder_mux_datapath (.*);

  function automatic int pick(input logic [3:0] g);
    int v = 0;
    if (g[0]) v = v | int'(reg_data);
    if (g[1]) v = v | (int'(reg_data) ^ 'hFFFF);
    if (g[2]) v = v | (int'(bus_data) ^ 'hFFFF);
    if (g[3]) v = v | ma;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int av, bv, s, cout, r, c, v, n;
    #1;
    av = (pick(a_gate_hi) & 'hFFFE) | (pick(a_gate_lo) & 1);
    bv = 0;
    if (b_gate[0]) bv = bv | int'(reg_data);
    if (b_gate[1]) bv = bv | int'(bus_data);
    if (b_gate[2]) bv = bv | mb;
    s = av + bv + int'(carry_in);
    cout = (s >> 16) & 1;
    s = s & 'hFFFF;
    case (out_mode)
      1: begin r = (s * 2) & 'hFFFF;             c = s >> 15; end
      2: begin r = (s / 2) | (s & 'h8000);       c = s & 1;   end
      3: begin r = ((s * 2) & 'hFFFF) | mc;      c = s >> 15; end
      4: begin r = (s / 2) | (mc * 'h8000);      c = s & 1;   end
      5: begin r = ((s & 'hFF) * 256) + (s / 256); c = 0;     end
      default: begin r = s; c = cout; end
    endcase
    n = r >> 15;
    if (out_mode inside {3'd1, 3'd2, 3'd3, 3'd4}) v = n ^ c;
    else if (out_mode == 3'd5) v = 0;
    else begin
      int sa, sb, ss;
      sa = (av >= 'h8000) ? av - 'h10000 : av;
      sb = (bv >= 'h8000) ? bv - 'h10000 : bv;
      ss = sa + sb + int'(carry_in);
      v = (ss > 32767 || ss < -32768) ? 1 : 0;
    end
    check({tag, " result"}, int'(result), r);
    check({tag, " flags"}, int'({flag_n, flag_z, flag_v, flag_c}), (mn * 8) + (mz * 4) + (mv * 2) + mc);
    @(posedge clk);
    if (a_capture) ma = av;
    if (b_capture) mb = bv;
    if (flags_load) begin mn = n; mz = (r == 0); mv = v; mc = c; end
    @(negedge clk);
  endtask

  task automatic idle();
    a_gate_hi = 0; a_gate_lo = 0; b_gate = 0; a_capture = 0; b_capture = 0;
    carry_in = 0; out_mode = 0; flags_load = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: latches zero after reset, shown by selecting both latches
    a_gate_hi = 4'b1000; a_gate_lo = 4'b1000; b_gate = 3'b100; step("R1");
    idle(); reg_data = 16'hA5A5; bus_data = 16'h3C3C; step("R2");
    carry_in = 1; step("R2");
    // R3: OR of several sources
    idle(); a_gate_hi = 4'b0101; a_gate_lo = 4'b0101; step("R3");
    idle(); b_gate = 3'b011; step("R3");
    // R4: constants
    idle(); reg_data = 16'h1234; a_gate_hi = 4'b0011; a_gate_lo = 4'b0011; step("R4");
    a_gate_lo = 0; step("R4");
    a_gate_hi = 0; a_gate_lo = 4'b0011; step("R4");
    // R5: capture then feedback after inputs change
    idle(); reg_data = 16'h1357; a_gate_hi = 1; a_gate_lo = 1; a_capture = 1;
    bus_data = 16'h0F0F; b_gate = 3'b010; b_capture = 1; step("R5");
    idle(); reg_data = 16'hFFFF; bus_data = 16'h0000;
    a_gate_hi = 4'b1000; a_gate_lo = 4'b1000; step("R5");
    idle(); b_gate = 3'b100; step("R5");
    // R6 and R10: add, subtract, overflow, carry, zero
    idle(); reg_data = 16'h7FFF; bus_data = 16'h0001; a_gate_hi = 1; a_gate_lo = 1;
    b_gate = 3'b010; flags_load = 1; step("R6");
    step("R10");
    idle(); reg_data = 16'h0005; bus_data = 16'h0005; a_gate_hi = 4'b0100; a_gate_lo = 4'b0100;
    b_gate = 3'b001; carry_in = 1; flags_load = 1; step("R6");
    out_mode = 3'd7; reg_data = 16'h0009; step("R6");
    idle(); step("R10");
    // R7: shifts, including a branch-style word offset doubling
    idle(); reg_data = 16'hC003; b_gate = 1; out_mode = 1; flags_load = 1; step("R7");
    out_mode = 2; step("R7");
    reg_data = 16'h0FF0; bus_data = 16'h1000; a_gate_hi = 4'b0100; a_gate_lo = 4'b0100;
    b_gate = 3'b001; carry_in = 1; out_mode = 1; step("R7");
    // R8: rotates through stored carry
    idle(); reg_data = 16'h8001; b_gate = 1; out_mode = 3; flags_load = 1; step("R8");
    step("R8");
    out_mode = 4; step("R8");
    step("R8");
    // R9: byte swap
    idle(); reg_data = 16'h12F0; b_gate = 1; out_mode = 5; flags_load = 1; step("R9");
    reg_data = 16'h0000; step("R9");
    // R10: flags hold without load
    idle(); reg_data = 16'hFFFF; b_gate = 1; step("R10");
    // R11: AND in two passes
    for (int k = 0; k < 3; k++) begin
      logic [15:0] x, y;
      x = 16'hF0F0 ^ (16'h1111 * k); y = 16'hCC33 + 16'h0101 * k;
      idle(); reg_data = x; bus_data = y; a_gate_hi = 4'b0110; a_gate_lo = 4'b0110; step("R11");
      reg_data = ~x | ~y; a_gate_hi = 4'b0010; a_gate_lo = 4'b0010; step("R11");
      check("R11 and", int'(result), int'(x & y));
    end
    idle(); step("R2");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule